// File: doc/BRIEF.md
# Two-Phase Write Update Sequencer

This block is the central sequencer of an update-based coherence scheme for a set of processor caches (four by default). A processor hands it one write, made of its own index, an address and a data word. The sequencer sends that update to every other cache and records an acknowledgment from each of them. When the last acknowledgment arrives, it tells the writer that its write is complete. In the same cycle it sends a second message to every updated cache, and from that cycle on each of them may return the new value to local reads.

Until that second message, each updated cache is told to hold its readers on the old value. A write that reaches the caches at different times therefore becomes visible everywhere in the same cycle, so the write looks atomic. The sequencer tracks one write at a time. A new request, whatever its address, is held off until the write in flight has gone through both phases, which also serializes writes to the same location.

Top module: `upd_ack_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and upd_valid, read_hold, wr_done and final_vis are all 0.
- R2: A request is taken only when req_valid and req_ready are both 1 at a clock edge. req_ready is 1 only in the idle state and stays 0 from the taking edge until the sequencer is idle again.
- R3: In the cycle after a request is taken, upd_valid is 1 for one cycle on every processor bit except the writer's (bit i stands for processor i), and upd_addr and upd_data equal the request's address and data.
- R4: read_hold is 1 for every processor except the writer from the update cycle up to the final-message cycle, and 0 in the final-message cycle.
- R5: Acknowledgments (ack_in bit i from processor i) may come in any order, several in one cycle, or with idle cycles between them. Phase one ends only at the edge where every processor except the writer has acknowledged.
- R6: A repeated acknowledgment from a processor that has already acknowledged, and an acknowledgment from the writer itself, neither counts nor ends phase one.
- R7: wr_done is 1 only on the writer's bit, for exactly one cycle: the cycle after the edge that took the last missing acknowledgment.
- R8: final_vis is 1 for one cycle on every processor except the writer, in the same cycle as wr_done.
- R9: After the final-message cycle comes exactly one cycle with req_ready 0, and then req_ready is 1. A request held valid during a write is taken only then, and its update carries its own address and data.
- R10: An acknowledgment present in the update cycle, before the sequencer waits for acknowledgments, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A write request is offered |
| req_ready | output | 1 | The sequencer can take a request |
| req_writer | input | 2 | Index of the writing processor |
| req_addr | input | 16 | Write address |
| req_data | input | 32 | Write data |
| upd_valid | output | 4 | Update message, one bit per processor |
| upd_addr | output | 16 | Address of the write in flight |
| upd_data | output | 32 | Data of the write in flight |
| ack_in | input | 4 | Update acknowledgment, one bit per processor |
| read_hold | output | 4 | Processor must keep reads on the old value |
| wr_done | output | 4 | Write-complete pulse to the writer |
| final_vis | output | 4 | Second-phase pulse: new value may be read |

## Verification
The acknowledgment phase is driven with several patterns. Single acknowledgments arrive in ascending order with no gaps. Then acknowledgments come with gaps, repeats and a self-acknowledgment from the writer, which shows whether the tracker counts a processor twice or counts the writer. Two acknowledgments in one cycle show that arrivals in the same cycle are merged. An acknowledgment sent in the update cycle shows whether the tracker opens too early. A second request, for the same address, is held valid during a write, which shows whether it can slip in before the write in flight is complete. Every test uses a different writer, so an error in the writer's mask or in which bit the completion goes to shows up.

// File: rtl/upd_ack_pkg.sv
package upd_ack_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SEND_UPD = 3'd1,
    ST_WAIT_ACK = 3'd2,
    ST_SEND_FIN = 3'd3,
    ST_DONE     = 3'd4
  } upd_state_e;

endpackage

// File: rtl/upd_ack_fsm.sv
module upd_ack_fsm
  import upd_ack_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_take,
  input  logic       phase1_end,
  output upd_state_e state
);

  upd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (req_take) state_d = ST_SEND_UPD;
      ST_SEND_UPD: state_d = ST_WAIT_ACK;
      ST_WAIT_ACK: if (phase1_end) state_d = ST_SEND_FIN;
      ST_SEND_FIN: state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/upd_ack_track.sv
module upd_ack_track #(
  parameter int PROC_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              open,
  input  logic [PROC_N-1:0] writer_mask,
  input  logic [PROC_N-1:0] ack_in,
  output logic              all_seen
);

  logic [PROC_N-1:0] seen_q;
  logic [PROC_N-1:0] gated_ack;

  assign gated_ack = open ? (ack_in & ~writer_mask) : '0;

  for (genvar i = 0; i < PROC_N; i++) begin : g_bit
    logic set_en;
    assign set_en = gated_ack[i] & ~seen_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      seen_q[i] <= 1'b0;
      else if (clr)    seen_q[i] <= 1'b0;
      else if (set_en) seen_q[i] <= 1'b1;
    end
  end

  assign all_seen = open & (&(seen_q | gated_ack | writer_mask));

endmodule

// File: rtl/upd_ack_payload.sv
module upd_ack_payload #(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ID_W-1:0]   in_writer,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic [ID_W-1:0]   writer,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      writer <= '0;
      addr   <= '0;
      data   <= '0;
    end else if (load) begin
      writer <= in_writer;
      addr   <= in_addr;
      data   <= in_data;
    end
  end

endmodule

// File: rtl/upd_ack_ctrl.sv
module upd_ack_ctrl
  import upd_ack_pkg::*;
#(
  parameter int PROC_N = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int ID_W  = (PROC_N > 1) ? $clog2(PROC_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_writer,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic [PROC_N-1:0] upd_valid,
  output logic [ADDR_W-1:0] upd_addr,
  output logic [DATA_W-1:0] upd_data,
  input  logic [PROC_N-1:0] ack_in,
  output logic [PROC_N-1:0] read_hold,
  output logic [PROC_N-1:0] wr_done,
  output logic [PROC_N-1:0] final_vis
);

  localparam logic [PROC_N-1:0] ONE_HOT0 = {{(PROC_N-1){1'b0}}, 1'b1};

  logic       rst_meta, rst_sync_n;
  upd_state_e state;
  logic       req_take, phase1_end;
  logic [ID_W-1:0]   writer_q;
  logic [PROC_N-1:0] writer_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign req_take  = req_valid & req_ready;

  upd_ack_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_take   (req_take),
    .phase1_end (phase1_end),
    .state      (state)
  );

  upd_ack_payload #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_payload (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (req_take),
    .in_writer (req_writer),
    .in_addr   (req_addr),
    .in_data   (req_data),
    .writer    (writer_q),
    .addr      (upd_addr),
    .data      (upd_data)
  );

  assign writer_mask = ONE_HOT0 << writer_q;

  upd_ack_track #(.PROC_N(PROC_N)) u_track (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .clr         (req_take),
    .open        (state == ST_WAIT_ACK),
    .writer_mask (writer_mask),
    .ack_in      (ack_in),
    .all_seen    (phase1_end)
  );

  assign upd_valid = (state == ST_SEND_UPD) ? ~writer_mask : '0;
  assign read_hold = ((state == ST_SEND_UPD) || (state == ST_WAIT_ACK)) ? ~writer_mask : '0;
  assign wr_done   = (state == ST_SEND_FIN) ? writer_mask : '0;
  assign final_vis = (state == ST_SEND_FIN) ? ~writer_mask : '0;

endmodule

// File: rtl/upd_ack_ctrl_chk.sv
module upd_ack_ctrl_chk #(
  parameter int PROC_N = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [PROC_N-1:0] upd_valid,
  input logic [PROC_N-1:0] read_hold,
  input logic [PROC_N-1:0] wr_done,
  input logic [PROC_N-1:0] final_vis
);

  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_update_fanout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ($countones(upd_valid) == PROC_N - 1));

  assert_update_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid != '0) |=> (upd_valid == '0));

  assert_hold_until_final_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (final_vis != '0) |-> ((read_hold == '0) && ($past(read_hold) == final_vis)));

  assert_done_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_done));

  assert_final_pairs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done != '0) |-> (final_vis == ~wr_done));

  assert_done_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done != '0) |=> (!req_ready ##1 req_ready));

endmodule

bind upd_ack_ctrl upd_ack_ctrl_chk #(.PROC_N(PROC_N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .upd_valid (upd_valid),
  .read_hold (read_hold),
  .wr_done   (wr_done),
  .final_vis (final_vis)
);

// File: tb/upd_ack_ctrl_tb.sv
module upd_ack_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_writer = '0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [3:0]  upd_valid;
  logic [15:0] upd_addr;
  logic [31:0] upd_data;
  logic [3:0]  ack_in = '0;
  logic [3:0]  read_hold;
  logic [3:0]  wr_done;
  logic [3:0]  final_vis;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  upd_ack_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_writer(req_writer),
    .req_addr(req_addr), .req_data(req_data),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_data(upd_data),
    .ack_in(ack_in), .read_hold(read_hold), .wr_done(wr_done), .final_vis(final_vis)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] others(input int w);
    return ~(4'b0001 << w);
  endfunction

  task automatic pulse_ack(input logic [3:0] v);
    ack_in = v;
    @(negedge clk);
    ack_in = '0;
  endtask

  // Offer a request, check the update cycle; return in the first wait cycle.
  task automatic start_write(input int w, input logic [15:0] a, input logic [31:0] d,
                             input logic [3:0] early);
    req_valid = 1'b1; req_writer = 2'(w); req_addr = a; req_data = d;
    @(negedge clk);
    chk("R3 update mask", {28'd0, upd_valid}, {28'd0, others(w)});
    chk("R3 update addr", {16'd0, upd_addr}, {16'd0, a});
    chk("R3 update data", upd_data, d);
    chk("R2 ready low", {31'd0, req_ready}, 32'd0);
    chk("R4 hold set", {28'd0, read_hold}, {28'd0, others(w)});
    req_valid = 1'b0;
    ack_in = early;
    @(negedge clk);
    ack_in = '0;
    chk("R3 update single", {28'd0, upd_valid}, 32'd0);
  endtask

  task automatic check_final(input int w);
    chk("R7 done", {28'd0, wr_done}, {28'd0, 4'b0001 << w});
    chk("R8 final", {28'd0, final_vis}, {28'd0, others(w)});
    chk("R4 hold clear", {28'd0, read_hold}, 32'd0);
    @(negedge clk);
    chk("R7 done single", {28'd0, wr_done}, 32'd0);
    chk("R9 done cycle", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    chk("R9 idle again", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 outputs", {16'd0, upd_valid, read_hold, wr_done, final_vis}, 32'd0);
  endtask

  task automatic t_in_order();
    start_write(0, 16'h1000, 32'hA5A5_0001, 4'b0000);
    pulse_ack(4'b0010);
    pulse_ack(4'b0100);
    chk("R5 not yet done", {28'd0, wr_done}, 32'd0);
    pulse_ack(4'b1000);
    check_final(0);
  endtask

  task automatic t_dup_self();
    start_write(2, 16'h2222, 32'h0000_BEEF, 4'b0000);
    pulse_ack(4'b1000);
    pulse_ack(4'b1000);
    pulse_ack(4'b0100);
    @(negedge clk);
    chk("R6 dup/self ignored", {28'd0, wr_done}, 32'd0);
    chk("R6 still holding", {28'd0, read_hold}, {28'd0, others(2)});
    pulse_ack(4'b0011);
    check_final(2);
  endtask

  task automatic t_early_ack();
    start_write(1, 16'h3030, 32'h1234_5678, 4'b1101);
    @(negedge clk);
    chk("R10 early ack ignored", {28'd0, wr_done}, 32'd0);
    chk("R10 still holding", {28'd0, read_hold}, {28'd0, others(1)});
    pulse_ack(4'b1001);
    chk("R5 partial", {28'd0, wr_done}, 32'd0);
    pulse_ack(4'b0100);
    check_final(1);
  endtask

  task automatic t_serialize();
    req_valid = 1'b1; req_writer = 2'd3; req_addr = 16'h4444; req_data = 32'h0000_0003;
    @(negedge clk);
    chk("R3 first mask", {28'd0, upd_valid}, {28'd0, others(3)});
    req_writer = 2'd0; req_data = 32'h0000_0B0B;
    @(negedge clk);
    chk("R2 second held", {31'd0, req_ready}, 32'd0);
    pulse_ack(4'b0111);
    chk("R7 first done", {28'd0, wr_done}, {28'd0, 4'b1000});
    chk("R8 first final", {28'd0, final_vis}, {28'd0, others(3)});
    @(negedge clk);
    chk("R9 second waits", {28'd0, upd_valid}, 32'd0);
    @(negedge clk);
    chk("R9 ready before take", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 second mask", {28'd0, upd_valid}, {28'd0, others(0)});
    chk("R9 second data", upd_data, 32'h0000_0B0B);
    chk("R9 second addr", {16'd0, upd_addr}, 32'h0000_4444);
    @(negedge clk);
    pulse_ack(4'b1110);
    check_final(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_in_order();
    t_dup_self();
    t_early_ack();
    t_serialize();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule